// File: doc/BRIEF.md
# Seconds Counter Register Core

This block is the register-side core of an elapsed-seconds clock. It holds a free-running 32-bit binary seconds counter, a 24-bit down-counting watchdog/alarm counter, a control byte, a status byte and a charger configuration byte, all reached through one auto-incrementing byte pointer. A serial bus front end drives it with a pointer load, byte read and write strobes, and one-cycle pulses that mark the start and stop of each bus transaction.

Reads of the seconds counter come from a shadow copy, so a multibyte read stays coherent while the live counter keeps running. The shadow copy is refreshed when a transaction starts, when it stops, and when the pointer wraps from the last register back to zero. Writes to the seconds counter collect in a holding register and reach the live counter in one step when the transaction stops. A prescaler divides the system clock down to a one-second tick. A power-fail input shuts off all bus access until a release delay has run out after power is good again.

Top module: `rtc_regcore`

## Requirements
- R1: After reset the seconds counter, its shadow copy, the watchdog counter, the control byte and the charger byte are zero. The pointer is 0. The status byte reads 0x80 (stop flag in bit 7 set, alarm flag in bit 0 clear). `rst_out_n` is low.
- R2: Register map: seconds counter at 0..3 with the least significant byte at 0; watchdog counter at 4..6 with the least significant byte at 4; control at 7; status at 8; charger configuration at 9. Bytes 4..7 and 9 read back what was written.
- R3: `ptr_load` sets the pointer to `ptr_addr`, and any address above 9 loads 0. Each accepted read or write advances the pointer by one. The step after address 9 goes to 0.
- R4: `rd_data` takes the byte at the pointer on the clock edge that samples `rd_en`, and holds it until the next accepted read. When `wr_en` is also high, the read is not taken.
- R5: Reads of addresses 0..3 return the shadow copy. The shadow is loaded from the live counter on an accepted start, an accepted stop, or a pointer wrap to 0, and it does not change at any other time.
- R6: A write to addresses 0..3 updates a holding register that is loaded from the live counter at each start. At the stop that ends a transaction containing such a write, the whole holding value is copied into the live counter. Before that stop the live counter is unchanged.
- R7: While control bit 7 is clear, `sec_tick` is high for one cycle in every TICK_DIV cycles. Each tick adds one to the seconds counter, and 0xFFFFFFFF rolls over to 0.
- R8: A write to any of addresses 0..3 restarts the prescaler. `sec_tick` next rises TICK_DIV-1 cycles after the write edge, and the counter steps on the edge after that.
- R9: Setting control bit 7 stops the prescaler and freezes the seconds counter, and it sets status bit 7. Status bit 7 clears only on a status write with bit 7 at 0 while control bit 7 is clear. Writing 1 to it has no effect.
- R10: On each tick the watchdog counter steps down by one while it is nonzero. The step from 1 to 0 sets status bit 0, which clears only when status is written with bit 0 at 0. Status bits 6..1 always read 0.
- R11: `rst_out_n` drops on the edge after `pfail` is sampled high. It stays low for RST_HOLD cycles after `pfail` is sampled low, then rises. While it is low, reads, writes, pointer loads, starts and stops are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfail | input | 1 | Supply below the power-fail threshold |
| rst_out_n | output | 1 | Active-low reset output; bus access is allowed while high |
| bus_start | input | 1 | One-cycle pulse at the start of a bus transaction |
| bus_stop | input | 1 | One-cycle pulse at the end of a bus transaction |
| ptr_load | input | 1 | Load the register pointer from `ptr_addr` |
| ptr_addr | input | 4 | Register address to load |
| wr_en | input | 1 | Write `wr_data` to the register at the pointer |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read the register at the pointer into `rd_data` |
| rd_data | output | 8 | Last byte read |
| sec_tick | output | 1 | One-cycle pulse each second |

## Verification
The bench aims at the edges of shadow coherence: a re-read of the same byte after a tick, which must still show the old value, and a wrap from register 9 to 0, which must reload. A design that refreshed the shadow on every read, or never on a wrap, returns the wrong count there. A partial seconds write is read back before and after its stop, so a design that writes straight into the live counter shows a torn value too early. The prescaler restart is timed to the exact cycle of the next tick, and the same check goes through the all-ones rollover. The stop and alarm flags are written with ones and then zeros, so a flag that a written 1 could set, or that a written 0 clears while held, is caught. During power fail, writes and pointer loads are attempted, and the release delay is counted cycle by cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int TOD_BYTES = 4;
  localparam int WD_BYTES  = 3;
  localparam int NUM_REGS  = TOD_BYTES + WD_BYTES + 3;
  localparam int ADDR_W    = $clog2(NUM_REGS);
  localparam int TOD_W     = 8 * TOD_BYTES;
  localparam int WD_W      = 8 * WD_BYTES;
  localparam int TIDX_W    = $clog2(TOD_BYTES);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [7:0]        byte_t;

  localparam addr_t A_WD0  = addr_t'(TOD_BYTES);
  localparam addr_t A_CTRL = addr_t'(TOD_BYTES + WD_BYTES);
  localparam addr_t A_STAT = addr_t'(TOD_BYTES + WD_BYTES + 1);
  localparam addr_t A_CHRG = addr_t'(TOD_BYTES + WD_BYTES + 2);
  localparam addr_t A_LAST = A_CHRG;

  localparam int OSC_OFF_BIT = 7;
  localparam int STOP_FLAG_BIT = 7;
  localparam int ALARM_FLAG_BIT = 0;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run)   cnt_d = '0;
    else if (cnt_q == TOP) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  assign tick = run && !restart && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: no tick while the oscillator is off
  a_r7_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  generate
    if (DIV > 1) begin : g_spacing
      // R7: ticks never come back to back
      a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
      // R8: a restart pushes the next tick out
      a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rtc_ptr.sv
module rtc_ptr
  import rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  addr_t load_addr,
  input  logic  step,
  output addr_t ptr,
  output logic  wrap
);
  addr_t ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    wrap  = 1'b0;
    if (load) begin
      ptr_d = (load_addr > A_LAST) ? '0 : load_addr;
    end else if (step) begin
      if (ptr_q == A_LAST) begin
        ptr_d = '0;
        wrap  = 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R3: the pointer never leaves the register space
  a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= A_LAST);
  // R3: a wrap lands on address zero
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ptr_q == '0));
endmodule

// File: rtl/rtc_pwr_gate.sv
module rtc_pwr_gate #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pfail,
  output logic access
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          acc_q, acc_d;

  always_comb begin
    if (pfail)             cnt_d = CW'(HOLD);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
    acc_d = !pfail && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(HOLD);
      acc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  assign access = acc_q;

  // R11: a power fail closes access on the next edge
  a_r11_pf_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pfail |=> !acc_q);
  // R11: access only opens with power good
  a_r11_open_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_q) |-> !$past(pfail));
endmodule

// File: rtl/rtc_tod.sv
module rtc_tod
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              stop,
  input  logic              snap,
  input  logic              wr,
  input  logic [TIDX_W-1:0] wr_idx,
  input  byte_t             wr_data,
  output logic [TOD_W-1:0]  shadow
);
  logic [TOD_W-1:0] live_q, live_d;
  logic [TOD_W-1:0] hold_q, hold_d;
  logic [TOD_W-1:0] shad_q, shad_d;
  logic             dirty_q, dirty_d;
  logic             commit;

  assign commit = stop && dirty_q;

  always_comb begin
    hold_d = hold_q;
    if (start) hold_d = live_q;
    if (wr) begin
      for (int b = 0; b < TOD_BYTES; b++) begin
        if (wr_idx == TIDX_W'(b)) hold_d[8*b +: 8] = wr_data;
      end
    end

    dirty_d = dirty_q;
    if (stop)    dirty_d = 1'b0;
    else if (wr) dirty_d = 1'b1;

    live_d = live_q;
    if (commit)    live_d = hold_q;
    else if (tick) live_d = live_q + 1'b1;

    shad_d = snap ? live_q : shad_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      hold_q  <= '0;
      shad_q  <= '0;
      dirty_q <= 1'b0;
    end else begin
      live_q  <= live_d;
      hold_q  <= hold_d;
      shad_q  <= shad_d;
      dirty_q <= dirty_d;
    end
  end

  assign shadow = shad_q;

  // R5: the shadow only moves on a snapshot event
  a_r5_shadow_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(shad_q));
  // R6: the held value lands whole at the stop
  a_r6_commit_whole: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (live_q == $past(hold_q)));
  // R7: one step per tick, rolling over at the top
  a_r7_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !commit) |=> (live_q == $past(live_q) + 1'b1));
  // R6: without a tick or commit the live count holds
  a_r6_live_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !commit) |=> $stable(live_q));
endmodule

// File: rtl/rtc_regcore.sv
module rtc_regcore
  import rtc_pkg::*;
#(
  parameter int TICK_DIV = 32768,
  parameter int RST_HOLD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfail,
  output logic              rst_out_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              sec_tick
);
  logic access;
  logic ev_start, ev_stop, ev_load, ev_wr, ev_rd, ev_step;
  addr_t ptr;
  logic  wrap;
  logic  tick;
  logic  tod_wr, wd_wr, snap;
  addr_t wd_off;
  logic [TOD_W-1:0] shadow;

  logic [WD_W-1:0] wd_q, wd_d;
  byte_t           ctrl_q, ctrl_d;
  byte_t           chrg_q, chrg_d;
  logic            stopf_q, stopf_d;
  logic            alarm_q, alarm_d;
  byte_t           rd_q, rd_d, rd_byte;
  logic            osc_run, wd_hit;

  rtc_pwr_gate #(.HOLD(RST_HOLD)) u_pwr (
    .clk    (clk),
    .rst_n  (rst_n),
    .pfail  (pfail),
    .access (access)
  );

  assign ev_start = bus_start && access;
  assign ev_stop  = bus_stop  && access;
  assign ev_load  = ptr_load  && access;
  assign ev_wr    = wr_en     && access;
  assign ev_rd    = rd_en     && access && !wr_en;
  assign ev_step  = ev_wr || ev_rd;

  rtc_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_load),
    .load_addr (ptr_addr),
    .step      (ev_step),
    .ptr       (ptr),
    .wrap      (wrap)
  );

  assign tod_wr  = ev_wr && (ptr < A_WD0);
  assign wd_wr   = ev_wr && (ptr >= A_WD0) && (ptr < A_CTRL);
  assign wd_off  = ptr - A_WD0;
  assign snap    = ev_start || ev_stop || wrap;
  assign osc_run = !ctrl_q[OSC_OFF_BIT];

  rtc_prescaler #(.DIV(TICK_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (osc_run),
    .restart (tod_wr),
    .tick    (tick)
  );

  rtc_tod u_tod (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .start   (ev_start),
    .stop    (ev_stop),
    .snap    (snap),
    .wr      (tod_wr),
    .wr_idx  (ptr[TIDX_W-1:0]),
    .wr_data (wr_data),
    .shadow  (shadow)
  );

  // watchdog/alarm counter and flags
  assign wd_hit = tick && !wd_wr && (wd_q == WD_W'(1));

  always_comb begin
    wd_d = wd_q;
    if (wd_wr) begin
      for (int b = 0; b < WD_BYTES; b++) begin
        if (wd_off == addr_t'(b)) wd_d[8*b +: 8] = wr_data;
      end
    end else if (tick && (wd_q != '0)) begin
      wd_d = wd_q - 1'b1;
    end

    ctrl_d = ctrl_q;
    if (ev_wr && (ptr == A_CTRL)) ctrl_d = wr_data;

    chrg_d = chrg_q;
    if (ev_wr && (ptr == A_CHRG)) chrg_d = wr_data;

    stopf_d = stopf_q;
    if (ctrl_q[OSC_OFF_BIT])
      stopf_d = 1'b1;
    else if (ev_wr && (ptr == A_STAT) && !wr_data[STOP_FLAG_BIT])
      stopf_d = 1'b0;

    alarm_d = alarm_q;
    if (wd_hit)
      alarm_d = 1'b1;
    else if (ev_wr && (ptr == A_STAT) && !wr_data[ALARM_FLAG_BIT])
      alarm_d = 1'b0;
  end

  // read path
  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < TOD_BYTES; b++) begin
      if (ptr == addr_t'(b)) rd_byte = shadow[8*b +: 8];
    end
    for (int b = 0; b < WD_BYTES; b++) begin
      if (ptr == addr_t'(TOD_BYTES + b)) rd_byte = wd_q[8*b +: 8];
    end
    if (ptr == A_CTRL) rd_byte = ctrl_q;
    if (ptr == A_STAT) begin
      rd_byte = '0;
      rd_byte[STOP_FLAG_BIT]  = stopf_q;
      rd_byte[ALARM_FLAG_BIT] = alarm_q;
    end
    if (ptr == A_CHRG) rd_byte = chrg_q;
    rd_d = ev_rd ? rd_byte : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q    <= '0;
      ctrl_q  <= '0;
      chrg_q  <= '0;
      stopf_q <= 1'b1;
      alarm_q <= 1'b0;
      rd_q    <= '0;
    end else begin
      wd_q    <= wd_d;
      ctrl_q  <= ctrl_d;
      chrg_q  <= chrg_d;
      stopf_q <= stopf_d;
      alarm_q <= alarm_d;
      rd_q    <= rd_d;
    end
  end

  assign rd_data   = rd_q;
  assign rst_out_n = access;
  assign sec_tick  = tick;

  // R9: a stopped oscillator keeps the stop flag set
  a_r9_stop_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[OSC_OFF_BIT] |=> stopf_q);
  // R10: reaching zero raises the alarm flag
  a_r10_alarm_set: assert property (@(posedge clk) disable iff (!rst_n)
    wd_hit |=> alarm_q);
  // R10: status reads never show the reserved bits
  a_r10_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd && (ptr == A_STAT)) |=> (rd_data[6:1] == 6'd0));
  // R11: blocked access leaves the plain registers alone
  a_r11_blocked_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> ($stable(ctrl_q) && $stable(chrg_q) && $stable(rd_q)));
  // R4: read data only changes on an accepted read
  a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rd |=> $stable(rd_q));
endmodule

// File: tb/test_rtc_regcore.sv
`timescale 1ns/1ps
module test_rtc_regcore;
  localparam int DIV  = 8;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n, pfail, bus_start, bus_stop, ptr_load, wr_en, rd_en;
  logic [3:0] ptr_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       rst_out_n, sec_tick;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rtc_regcore #(.TICK_DIV(DIV), .RST_HOLD(HOLD)) i_rtc_regcore (
    .clk       (clk),
    .rst_n     (rst_n),
    .pfail     (pfail),
    .rst_out_n (rst_out_n),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .ptr_load  (ptr_load),
    .ptr_addr  (ptr_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .sec_tick  (sec_tick)
  );

  typedef struct packed {
    logic [3:0] addr;
    logic [7:0] wdat;
    logic [7:0] expv;
  } vec_t;

  // oscillator is stopped while these run
  localparam vec_t VEC [8] = '{
    '{4'h9, 8'hA5, 8'hA5},   // R2 charger byte
    '{4'h9, 8'h3C, 8'h3C},   // R2
    '{4'h4, 8'h11, 8'h11},   // R2 watchdog byte 0
    '{4'h5, 8'h22, 8'h22},   // R2
    '{4'h6, 8'h33, 8'h33},   // R2
    '{4'h8, 8'hFF, 8'h80},   // R9 R10 ones do not set flags
    '{4'h8, 8'h00, 8'h80},   // R9 stop flag held while stopped
    '{4'h7, 8'h80, 8'h80}    // R2 control
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start;
    bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic do_stop;
    bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic setp(input logic [3:0] a);
    ptr_load = 1'b1; ptr_addr = a; @(negedge clk); ptr_load = 1'b0;
  endtask

  task automatic wrb(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdb(output logic [7:0] d);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, v0;
    rst_n = 1'b0; pfail = 1'b0; bus_start = 1'b0; bus_stop = 1'b0;
    ptr_load = 1'b0; ptr_addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    chk("R1 R11 rst_out_n low after reset", rst_out_n, 0);
    for (int i = 0; i < 50; i++) begin
      if (rst_out_n) break;
      cyc(1);
    end
    chk("R11 access opens after hold", rst_out_n, 1);

    // reset state, pointer starts at 0 and shadow is zero
    rdb(v); chk("R1 R4 shadow byte0 at reset", v, 8'h00);
    setp(4'h8); rdb(v); chk("R1 status at reset", v, 8'h80);
    setp(4'h7); rdb(v); chk("R1 control at reset", v, 8'h00);
    setp(4'h9); rdb(v); chk("R1 charger at reset", v, 8'h00);

    // stop the oscillator
    setp(4'h7); wrb(8'h80);

    // table of register write/read vectors
    for (int k = 0; k < 8; k++) begin
      do_start(); setp(VEC[k].addr); wrb(VEC[k].wdat); do_stop();
      do_start(); setp(VEC[k].addr); rdb(v); do_stop();
      chk($sformatf("R2 R9 R10 vector %0d", k), v, VEC[k].expv);
    end

    // full seconds write then multibyte read (R6 R2 R3)
    do_start(); setp(4'h0);
    wrb(8'h78); wrb(8'h56); wrb(8'h34); wrb(8'h12);
    do_stop();
    do_start(); setp(4'h0);
    rdb(v); chk("R6 R2 byte0", v, 8'h78);
    rdb(v); chk("R3 byte1 auto step", v, 8'h56);
    rdb(v); chk("R3 byte2", v, 8'h34);
    rdb(v); chk("R3 byte3", v, 8'h12);
    do_stop();

    // partial write is not visible before stop (R6)
    do_start(); setp(4'h0); wrb(8'hAA);
    setp(4'h0); rdb(v); chk("R6 no torn value before stop", v, 8'h78);
    do_stop();
    do_start(); setp(4'h0);
    rdb(v); chk("R6 committed byte0", v, 8'hAA);
    rdb(v); chk("R6 unwritten byte1 kept", v, 8'h56);
    do_stop();

    // out of range pointer load goes to 0 (R3)
    setp(4'hC); rdb(v); chk("R3 load above 9 gives 0", v, 8'hAA);

    // rollover (R7)
    do_start(); setp(4'h0);
    wrb(8'hFF); wrb(8'hFF); wrb(8'hFF); wrb(8'hFF);
    do_stop();
    do_start(); setp(4'h7); wrb(8'h00); do_stop();
    cyc(10);
    do_start(); setp(4'h3); rdb(v); do_stop();
    chk("R7 rollover to zero", v, 8'h00);

    // prescaler restart on seconds write (R8 R7)
    do_start(); setp(4'h0);
    wrb(8'hF0); wrb(8'h00); wrb(8'h00); wrb(8'h00);   // edge E
    do_stop();                                         // edge E+1
    for (int i = 2; i <= 7; i++) begin
      cyc(1);
      chk($sformatf("R8 tick at step %0d", i), sec_tick, (i == 7) ? 1 : 0);
    end
    cyc(1);                                            // E+8 counter steps
    do_start(); setp(4'h0); rdb(v);                    // E+11
    chk("R7 R8 one step after restart", v, 8'hF1);
    cyc(6);                                            // tick at E+16
    setp(4'h0); rdb(v);                                // E+19
    chk("R5 shadow steady without event", v, 8'hF1);
    setp(4'h9); rdb(v);                                // E+21 wrap reload
    chk("R2 charger before wrap", v, 8'h3C);
    rdb(v);                                            // E+22
    chk("R3 R5 wrap to 0 reloads shadow", v, 8'hF2);
    do_stop();

    // clear stop flag with oscillator running (R9)
    setp(4'h8); wrb(8'h00);
    setp(4'h8); rdb(v); chk("R9 stop flag cleared", v, 8'h00);

    // watchdog countdown and alarm flag (R10)
    setp(4'h4); wrb(8'h02); wrb(8'h00); wrb(8'h00);
    cyc(40);
    setp(4'h8); rdb(v); chk("R10 alarm set at zero", v, 8'h01);
    setp(4'h4); rdb(v); chk("R10 watchdog stops at zero", v, 8'h00);
    setp(4'h8); wrb(8'h01);
    setp(4'h8); rdb(v); chk("R10 writing one keeps alarm", v, 8'h01);
    setp(4'h8); wrb(8'h00);
    setp(4'h8); rdb(v); chk("R10 alarm cleared by zero", v, 8'h00);

    // power fail gating (R11)
    setp(4'h9);
    pfail = 1'b1; cyc(1);
    chk("R11 rst_out_n drops", rst_out_n, 0);
    wrb(8'h77);
    setp(4'h4);
    do_stop();
    pfail = 1'b0;
    for (int i = 0; i < HOLD; i++) begin
      cyc(1);
      chk($sformatf("R11 still held %0d", i), rst_out_n, 0);
    end
    cyc(1);
    chk("R11 released after hold", rst_out_n, 1);
    rdb(v); chk("R11 write and load ignored", v, 8'h3C);

    // oscillator stop sets the flag and freezes counting (R9)
    setp(4'h7); wrb(8'h80);
    setp(4'h8); rdb(v); chk("R9 stop flag set by oscillator off", v, 8'h80);
    do_start(); setp(4'h0); rdb(v0); do_stop();
    cyc(20);
    do_start(); setp(4'h0); rdb(v); do_stop();
    chk("R9 counter frozen", v, v0);

    summary();
    $finish;
  end
endmodule